// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Unit

This unit gathers the interrupt causes of a serial peripheral controller that has a transmit FIFO and a receive FIFO. Each cycle it watches the fill counts of both FIFOs and a one-cycle mode-fault pulse from the serial engine. From them it keeps a seven-bit status word. Some status bits follow a level condition. Others catch an event and hold it until software clears it.

Software reaches the unit through a small word-addressed register port. The status word is cleared by writing ones to it. The interrupt mask is never written as a whole: one write-only location sets mask bits and another clears them, and a separate location reads the mask back. Two threshold registers set the transmit watermark and the receive watermark. A single interrupt line is high whenever any status bit is set and enabled in the mask. The FIFOs and the shift engine sit outside this unit.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the status word and the mask read 0, both thresholds read 1 and irq_o is low.
- R2: Status bit 2 is high while the transmit count is below the transmit threshold. Status bit 6 is high while the transmit count equals the FIFO depth (63).
- R3: Status bit 4 is high while the receive count is nonzero. Status bit 5 is high while the receive count equals the FIFO depth.
- R4: Status bit 3 sets in the cycle after the receive count goes from below the receive threshold to at or above it. It then holds until it is cleared. Clearing it while the count stays at or above the threshold leaves it clear.
- R5: A mode-fault pulse sets status bit 0. The bit holds until it is cleared.
- R6: Writing to offset 0x04 clears each status bit whose write-data bit is 1. A level bit whose condition still holds reads 0 for one cycle and then sets again. A sticky event that arrives in the same cycle as its clear wins, so the bit stays set.
- R7: Writing to offset 0x08 ORs write-data bits 6:0 into the mask. Writing to 0x0C clears the mask bits that are 1 in the write data. Offset 0x10 reads the mask, and writes to 0x10 are ignored.
- R8: irq_o is high when at least one status bit is set and its mask bit is also set. Otherwise irq_o is low.
- R9: Offset 0x28 holds the transmit threshold and offset 0x2C holds the receive threshold. Each keeps the low 6 bits of the written word and reads them back zero-extended.
- R10: Writes to offsets other than 0x04, 0x08, 0x0C, 0x28 and 0x2C have no effect. Reads of any offset other than 0x04, 0x10, 0x28 and 0x2C return 0. Status bit 1 always reads 0.
- R11: The data for a read appears on reg_rdata_o, with reg_rvalid_o high for exactly one cycle, in the cycle after reg_rd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_rd_i |
| tx_level_i | input | 6 | Transmit FIFO fill count, 0 to 63 |
| rx_level_i | input | 6 | Receive FIFO fill count, 0 to 63 |
| mode_fault_i | input | 1 | One-cycle mode-fault event |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that a read strobe and a write strobe never occur in the same cycle. They also assume that the fill counts never exceed the FIFO depth and that each mode-fault pulse lasts one cycle. The stimulus issues register accesses one at a time from tasks, holds each count between 0 and 63, and raises the fault input for a single cycle only. Every read result is predicted from the requirements and queued when the read is issued. It is compared when the unit returns the data.

// File: rtl/ixr_pkg.sv
package ixr_pkg;
  localparam int NUM_IRQ = 7;

  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_EN    = 8'h08;
  localparam logic [7:0] OFF_DIS   = 8'h0C;
  localparam logic [7:0] OFF_MASK  = 8'h10;
  localparam logic [7:0] OFF_TXTHR = 8'h28;
  localparam logic [7:0] OFF_RXTHR = 8'h2C;

  localparam int IRQ_FAULT  = 0;
  localparam int IRQ_TXWM   = 2;
  localparam int IRQ_RXWM   = 3;
  localparam int IRQ_RXNE   = 4;
  localparam int IRQ_RXFULL = 5;
  localparam int IRQ_TXFULL = 6;

  // bits that hold an event until cleared; all others follow a level
  localparam logic [NUM_IRQ-1:0] STICKY_BITS = 7'b000_1001;
endpackage

// File: rtl/ixr_regif.sv
module ixr_regif
  import ixr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_IRQ-1:0] status_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  output logic [NUM_IRQ-1:0] clr_o,
  output logic [NUM_IRQ-1:0] en_o,
  output logic [NUM_IRQ-1:0] dis_o,
  output logic [CNT_W-1:0]   tx_thr_o,
  output logic [CNT_W-1:0]   rx_thr_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o
);
  logic [CNT_W-1:0]  tx_thr_q, rx_thr_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              rvalid_q;

  always_comb begin
    clr_o = '0;
    en_o  = '0;
    dis_o = '0;
    if (wr_i) begin
      if (addr_i == ADDR_W'(OFF_STAT)) clr_o = wdata_i[NUM_IRQ-1:0];
      if (addr_i == ADDR_W'(OFF_EN))   en_o  = wdata_i[NUM_IRQ-1:0];
      if (addr_i == ADDR_W'(OFF_DIS))  dis_o = wdata_i[NUM_IRQ-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_q <= CNT_W'(1);
      rx_thr_q <= CNT_W'(1);
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(OFF_TXTHR)) tx_thr_q <= wdata_i[CNT_W-1:0];
      if (addr_i == ADDR_W'(OFF_RXTHR)) rx_thr_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(OFF_STAT):  rd_mux = DATA_W'(status_i);
      ADDR_W'(OFF_MASK):  rd_mux = DATA_W'(mask_i);
      ADDR_W'(OFF_TXTHR): rd_mux = DATA_W'(tx_thr_q);
      ADDR_W'(OFF_RXTHR): rd_mux = DATA_W'(rx_thr_q);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rd_mux;
    end
  end

  assign tx_thr_o = tx_thr_q;
  assign rx_thr_o = rx_thr_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/ixr_status.sv
module ixr_status
  import ixr_pkg::*;
#(
  parameter int FIFO_DEPTH = 63,
  parameter int CNT_W      = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   tx_level_i,
  input  logic [CNT_W-1:0]   rx_level_i,
  input  logic               fault_i,
  input  logic [CNT_W-1:0]   tx_thr_i,
  input  logic [CNT_W-1:0]   rx_thr_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  output logic [NUM_IRQ-1:0] status_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic               rx_hit, rx_hit_q;
  logic [NUM_IRQ-1:0] cond;

  assign rx_hit = (rx_level_i >= rx_thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_hit_q <= 1'b0;
    else         rx_hit_q <= rx_hit;
  end

  always_comb begin
    cond             = '0;
    cond[IRQ_FAULT]  = fault_i;
    cond[IRQ_TXWM]   = (tx_level_i < tx_thr_i);
    cond[IRQ_RXWM]   = rx_hit & ~rx_hit_q;  // crossing only
    cond[IRQ_RXNE]   = (rx_level_i != '0);
    cond[IRQ_RXFULL] = (rx_level_i == FULL_CNT);
    cond[IRQ_TXFULL] = (tx_level_i == FULL_CNT);
  end

  for (genvar b = 0; b < NUM_IRQ; b++) begin : g_bit
    logic bit_q;
    if (STICKY_BITS[b]) begin : g_sticky
      // a new event beats a clear in the same cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= (bit_q & ~clr_i[b]) | cond[b];
      end
    end else begin : g_level
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= cond[b] & ~clr_i[b];
      end
    end
    assign status_o[b] = bit_q;
  end
endmodule

// File: rtl/ixr_mask.sv
module ixr_mask
  import ixr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] dis_i,
  input  logic [NUM_IRQ-1:0] status_i,
  output logic [NUM_IRQ-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | en_i) & ~dis_i;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(status_i & mask_q);
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import ixr_pkg::*;
#(
  parameter  int FIFO_DEPTH = 63,
  parameter  int ADDR_W     = 8,
  parameter  int DATA_W     = 32,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_rvalid_o,
  input  logic [CNT_W-1:0]  tx_level_i,
  input  logic [CNT_W-1:0]  rx_level_i,
  input  logic              mode_fault_i,
  output logic              irq_o
);
  logic [NUM_IRQ-1:0] status_w, mask_w, clr_w, en_w, dis_w;
  logic [CNT_W-1:0]   tx_thr_w, rx_thr_w;

  ixr_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status_w),
    .mask_i   (mask_w),
    .clr_o    (clr_w),
    .en_o     (en_w),
    .dis_o    (dis_w),
    .tx_thr_o (tx_thr_w),
    .rx_thr_o (rx_thr_w),
    .rdata_o  (reg_rdata_o),
    .rvalid_o (reg_rvalid_o)
  );

  ixr_status #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_level_i (tx_level_i),
    .rx_level_i (rx_level_i),
    .fault_i    (mode_fault_i),
    .tx_thr_i   (tx_thr_w),
    .rx_thr_i   (rx_thr_w),
    .clr_i      (clr_w),
    .status_o   (status_w)
  );

  ixr_mask u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_w),
    .dis_i    (dis_w),
    .status_i (status_w),
    .mask_o   (mask_w),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk #(
  parameter int FIFO_DEPTH = 63,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              reg_rvalid_o,
  input logic [CNT_W-1:0]  tx_level_i,
  input logic [CNT_W-1:0]  rx_level_i,
  input logic              mode_fault_i,
  input logic              irq_o,
  input logic [6:0]        status_w,
  input logic [6:0]        mask_w
);
  logic clr_hit0, clr_hit6, wr_en_reg, wr_dis_reg;
  assign clr_hit0   = reg_wr_i && (reg_addr_i == ADDR_W'(8'h04)) && reg_wdata_i[0];
  assign clr_hit6   = reg_wr_i && (reg_addr_i == ADDR_W'(8'h04)) && reg_wdata_i[6];
  assign wr_en_reg  = reg_wr_i && (reg_addr_i == ADDR_W'(8'h08));
  assign wr_dis_reg = reg_wr_i && (reg_addr_i == ADDR_W'(8'h0C));

  assert_rvalid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i |=> reg_rvalid_o);
  assert_no_rvalid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> !reg_rvalid_o);
  assert_fault_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_fault_i |=> status_w[0]);
  assert_fault_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_w[0] && !clr_hit0) |=> status_w[0]);
  assert_txfull_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_level_i == CNT_W'(FIFO_DEPTH)) && !clr_hit6) |=> status_w[6]);
  assert_rxempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_i == '0) |=> (!status_w[4] && !status_w[5]));
  assert_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_reg |=> ((mask_w & $past(reg_wdata_i[6:0])) == $past(reg_wdata_i[6:0])));
  assert_disable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dis_reg |=> ((mask_w & $past(reg_wdata_i[6:0])) == 7'd0));
  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_w == 7'd0) |-> !irq_o);
  assert_rsvd_bit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_w[1]);
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/spi_irq_ctrl_bench.sv
module spi_irq_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        reg_rvalid_o;
  logic [5:0]  tx_level_i = 6'd10;
  logic [5:0]  rx_level_i = 6'd0;
  logic        mode_fault_i = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    string       req;
    logic [31:0] exp;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  spi_irq_ctrl u_spi_irq_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: compares returned reads with the queued predictions
  always @(negedge clk_i) begin
    if (rst_ni && reg_rvalid_o) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11 act=unexpected rvalid exp=none");
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(it.req, reg_rdata_o, it.exp);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    sb_item_t it;
    it.req = req; it.exp = exp;
    sb_q.push_back(it);
    reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_fault();
    mode_fault_i = 1'b1;
    @(negedge clk_i);
    mode_fault_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    rd(8'h04, 32'h00, "R1 status");
    rd(8'h10, 32'h00, "R1 mask");
    rd(8'h28, 32'h01, "R1 txthr");
    rd(8'h2C, 32'h01, "R1 rxthr");

    // R9 thresholds keep low 6 bits
    wr(8'h28, 32'hFFFF_FF45);
    rd(8'h28, 32'h05, "R9 txthr");
    wr(8'h2C, 32'h0000_0004);
    rd(8'h2C, 32'h04, "R9 rxthr");

    // R2 transmit watermark and full
    tx_level_i = 6'd3;  tick(1); rd(8'h04, 32'h04, "R2 tx below thr");
    tx_level_i = 6'd5;  tick(1); rd(8'h04, 32'h00, "R2 tx at thr");
    tx_level_i = 6'd63; tick(1); rd(8'h04, 32'h40, "R2 tx full");
    tx_level_i = 6'd10; tick(1); rd(8'h04, 32'h00, "R2 tx mid");

    // R3 receive not-empty and full, R4 crossing latch
    rx_level_i = 6'd2;  tick(1); rd(8'h04, 32'h10, "R3 rx nonempty");
    rx_level_i = 6'd63; tick(1); rd(8'h04, 32'h38, "R3 rx full R4 cross");
    rx_level_i = 6'd1;  tick(1); rd(8'h04, 32'h18, "R4 sticky");
    wr(8'h04, 32'h08);           rd(8'h04, 32'h10, "R4 cleared");
    rx_level_i = 6'd4;  tick(1); rd(8'h04, 32'h18, "R4 reach exact");
    wr(8'h04, 32'h08);
    rd(8'h04, 32'h10, "R4 no reassert a");
    rd(8'h04, 32'h10, "R4 no reassert b");
    rx_level_i = 6'd0;  tick(1); rd(8'h04, 32'h00, "R3 rx empty");

    // R5 mode fault latch
    pulse_fault();
    rd(8'h04, 32'h01, "R5 fault set");
    tick(5);
    rd(8'h04, 32'h01, "R5 fault held");
    wr(8'h04, 32'h01);
    rd(8'h04, 32'h00, "R5 fault cleared");

    // R6 level bit reasserts after clear
    tx_level_i = 6'd63; tick(1);
    wr(8'h04, 32'h40);
    rd(8'h04, 32'h00, "R6 cleared one cycle");
    rd(8'h04, 32'h40, "R6 reasserted");
    tx_level_i = 6'd10; tick(1);
    // R6 event beats clear in same cycle
    mode_fault_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 8'h04; reg_wdata_i = 32'h01;
    @(negedge clk_i);
    mode_fault_i = 1'b0; reg_wr_i = 1'b0;
    rd(8'h04, 32'h01, "R6 set wins");
    wr(8'h04, 32'h7F);
    rd(8'h04, 32'h00, "R6 all cleared");

    // R7 mask set/clear/readback
    wr(8'h08, 32'h05);      rd(8'h10, 32'h05, "R7 enable");
    wr(8'h08, 32'h42);      rd(8'h10, 32'h47, "R7 enable or");
    wr(8'h0C, 32'h03);      rd(8'h10, 32'h44, "R7 disable");
    wr(8'h10, 32'h7F);      rd(8'h10, 32'h44, "R7 mask write ignored");
    rd(8'h08, 32'h00, "R10 enable reads zero");
    rd(8'h0C, 32'h00, "R10 disable reads zero");

    // R8 interrupt line
    tx_level_i = 6'd3;  tick(1); check("R8 masked src on", {31'd0, irq_o}, 32'd1);
    tx_level_i = 6'd10; tick(1); check("R8 src off", {31'd0, irq_o}, 32'd0);
    pulse_fault();               check("R8 unmasked src", {31'd0, irq_o}, 32'd0);
    wr(8'h08, 32'h01);           check("R8 enable fault", {31'd0, irq_o}, 32'd1);
    wr(8'h0C, 32'h7F);           check("R8 mask all off", {31'd0, irq_o}, 32'd0);
    wr(8'h04, 32'h01);

    // R10 reserved offsets
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h18, 32'h00, "R10 rsvd read");
    rd(8'h20, 32'h00, "R10 rsvd read b");
    rd(8'h10, 32'h00, "R10 mask untouched");
    rd(8'h28, 32'h05, "R10 txthr untouched");
    rd(8'h2C, 32'h04, "R10 rxthr untouched");
    rd(8'h04, 32'h00, "R10 status untouched");

    tick(4);
    check("R11 all reads returned", sb_q.size(), 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule